// File: doc/BRIEF.md
# Receive Line Idle Time-out Detector

This block watches a serial receiver for silence once traffic has begun. A bit-period tick and a character-received pulse come in from the receiver. A programmable time-out value sets the allowed silence in units of four bit periods. The block holds off until the first character arrives after a start command. It then counts bit-period ticks down from four times the programmed value, and every new character restarts the count. When the count runs out, a sticky time-out flag rises and the counter stops. A value of zero turns detection off.

Software issues a start command to arm a new wait for a first character, and a status-clear command to drop the flag without re-arming. Bit timing and the receiver itself sit outside this block.

Top module: `rx_idle_timer`

## Requirements
- R1: With a time-out value of 0 the flag never sets. A count already in progress is abandoned when the value becomes 0, and the block goes back to waiting for a first character.
- R2: After reset or a start command, bit-period ticks alone never set the flag until a character-received pulse arrives.
- R3: After the arming character, the flag is high in the cycle after the clock edge that samples the (4 × value)-th bit-period tick, and not before. Cycles without a tick do not count.
- R4: Each character-received pulse while counting reloads the full count of 4 × value ticks.
- R5: When a character pulse and a tick arrive in the same cycle, the reload wins and that tick is not counted.
- R6: Once the flag sets it stays high. The counter stops, and further ticks and characters have no effect until a start command.
- R7: A status-clear command drops the flag one cycle later and does not re-arm counting. Later characters and ticks leave the flag low.
- R8: A start command clears the flag one cycle later and restarts the wait for a first character. A character pulse in the same cycle as a start is ignored.
- R9: After synchronous active-high reset the flag is 0.
- R10: If a status-clear and the expiring tick arrive in the same cycle, the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rcvd | input | 1 | One-cycle pulse per received character |
| idle_limit | input | LIMIT_W | Time-out value in units of four bit periods; 0 disables |
| arm_cmd | input | 1 | Start command: clear flag, wait for first character |
| clr_cmd | input | 1 | Status-clear command for the flag |
| idle_flag | output | 1 | Sticky time-out flag (registered) |

## Verification
The bench builds the block with LIMIT_W = 4. At that width the largest value, 15, gives a 60-tick window, so a full-scale expiry is checked exactly as well as the short windows of value 2. The narrow width also keeps every race (reload against tick, clear against expiry, start against character) within a few dozen cycles, each placed on the exact edge where it matters.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } rxto_state_e;
endpackage

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               char_rcvd,
  input  logic               arm_cmd,
  input  logic [LIMIT_W-1:0] idle_limit,
  input  logic               cnt_last,
  output logic               load_en,
  output logic               dec_en,
  output logic               zero_en,
  output logic               expire,
  output rxto_state_e        state
);
  rxto_state_e state_d;
  logic        enabled;

  assign enabled = (idle_limit != '0);

  always_comb begin
    load_en = 1'b0;
    dec_en  = 1'b0;
    zero_en = 1'b0;
    expire  = 1'b0;
    state_d = state;
    if (arm_cmd) begin
      zero_en = 1'b1;
      state_d = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (char_rcvd && enabled) begin
            load_en = 1'b1;
            state_d = ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (!enabled) begin
            zero_en = 1'b1;
            state_d = ST_WAIT;
          end else if (char_rcvd) begin
            load_en = 1'b1;
          end else if (bit_tick) begin
            dec_en = 1'b1;
            if (cnt_last) begin
              expire  = 1'b1;
              state_d = ST_DONE;
            end
          end
        end
        default: begin
          state_d = state;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= state_d;
  end
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int LIMIT_W = 8,
  localparam int CNT_W  = LIMIT_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               dec_en,
  input  logic               zero_en,
  input  logic [LIMIT_W-1:0] idle_limit,
  output logic [CNT_W-1:0]   count,
  output logic               cnt_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_val;
  assign reload_val = {idle_limit, 2'b00};
  assign cnt_last   = (count == ONE);

  always_ff @(posedge clk) begin
    if (rst || zero_en) begin
      count <= '0;
    end else if (load_en) begin
      count <= reload_val;
    end else if (dec_en) begin
      count <= count - ONE;
    end
  end
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst,
  input  logic arm_cmd,
  input  logic expire,
  input  logic clr_cmd,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || arm_cmd) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (clr_cmd) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rxto_pkg::*;
#(
  parameter int LIMIT_W = 8,
  localparam int CNT_W  = LIMIT_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               char_rcvd,
  input  logic [LIMIT_W-1:0] idle_limit,
  input  logic               arm_cmd,
  input  logic               clr_cmd,
  output logic               idle_flag
);
  logic             load_en;
  logic             dec_en;
  logic             zero_en;
  logic             expire;
  logic             cnt_last;
  logic [CNT_W-1:0] count;
  rxto_state_e      state;

  rxto_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
    .arm_cmd(arm_cmd), .idle_limit(idle_limit), .cnt_last(cnt_last),
    .load_en(load_en), .dec_en(dec_en), .zero_en(zero_en),
    .expire(expire), .state(state)
  );

  rxto_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_en(load_en), .dec_en(dec_en),
    .zero_en(zero_en), .idle_limit(idle_limit),
    .count(count), .cnt_last(cnt_last)
  );

  rxto_flag u_flag (
    .clk(clk), .rst(rst), .arm_cmd(arm_cmd), .expire(expire),
    .clr_cmd(clr_cmd), .flag(idle_flag)
  );
endmodule

// File: rtl/rxto_chk.sv
module rxto_chk
  import rxto_pkg::*;
#(
  parameter int LIMIT_W = 8,
  localparam int CNT_W  = LIMIT_W + 2
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_tick,
  input logic               char_rcvd,
  input logic [LIMIT_W-1:0] idle_limit,
  input logic               arm_cmd,
  input logic               clr_cmd,
  input logic               idle_flag,
  input logic [CNT_W-1:0]   count,
  input rxto_state_e        state
);
  // R1
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $past(idle_limit) != '0);

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_flag && !arm_cmd && !clr_cmd) |=> idle_flag);

  // R8
  arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    arm_cmd |=> (!idle_flag && state == ST_WAIT));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (char_rcvd && !arm_cmd && state != ST_DONE && idle_limit != '0)
      |=> count == {$past(idle_limit), 2'b00});

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && bit_tick && !char_rcvd && !arm_cmd && idle_limit != '0)
      |=> count == $past(count) - CNT_W'(1));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !arm_cmd) |=> $stable(count));

  // R2
  wait_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !char_rcvd) |=> $stable(idle_flag) || !idle_flag);
endmodule

bind rx_idle_timer rxto_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
  .idle_limit(idle_limit), .arm_cmd(arm_cmd), .clr_cmd(clr_cmd),
  .idle_flag(idle_flag), .count(count), .state(state)
);

// File: tb/sim_rx_idle_timer.sv
module sim_rx_idle_timer;
  localparam int LIMIT_W = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bit_tick = 1'b0;
  logic               char_rcvd = 1'b0;
  logic [LIMIT_W-1:0] idle_limit = '0;
  logic               arm_cmd = 1'b0;
  logic               clr_cmd = 1'b0;
  logic               idle_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rx_idle_timer #(.LIMIT_W(LIMIT_W)) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
    .idle_limit(idle_limit), .arm_cmd(arm_cmd), .clr_cmd(clr_cmd),
    .idle_flag(idle_flag)
  );

  // one cycle: drive inputs after an edge, let the next edge take them
  task automatic step(input logic t, input logic c, input logic a, input logic k);
    bit_tick = t; char_rcvd = c; arm_cmd = a; clr_cmd = k;
    @(posedge clk); #1;
    bit_tick = 0; char_rcvd = 0; arm_cmd = 0; clr_cmd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (idle_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: idle_flag=%b expected %b at %0t", req, idle_flag, exp, $time);
    end
  endtask

  task automatic t_reset();
    check(1'b0, "R9 reset");
  endtask

  task automatic t_no_char();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    ticks(20);
    check(1'b0, "R2 ticks without character");
  endtask

  task automatic t_basic();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    for (int i = 0; i < 7; i++) begin step(1, 0, 0, 0); step(0, 0, 0, 0); end
    check(1'b0, "R3 before last tick");
    step(1, 0, 0, 0);
    check(1'b1, "R3 expiry after 8 ticks");
  endtask

  task automatic t_reload();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(6);
    step(0, 1, 0, 0);
    ticks(7);
    check(1'b0, "R4 reload restarts window");
    ticks(1);
    check(1'b1, "R4 expiry after reload");
  endtask

  task automatic t_priority();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(7);
    step(1, 1, 0, 0);
    ticks(7);
    check(1'b0, "R5 reload beats tick");
    ticks(1);
    check(1'b1, "R5 expiry after tied reload");
  endtask

  task automatic t_sticky_clear();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(8);
    for (int i = 0; i < 10; i++) begin step(1, 0, 0, 0); step(0, 1, 0, 0); end
    check(1'b1, "R6 flag sticky after expiry");
    step(0, 0, 0, 1);
    check(1'b0, "R7 clear drops flag");
    step(0, 1, 0, 0);
    ticks(20);
    check(1'b0, "R7 clear does not re-arm");
  endtask

  task automatic t_zero();
    idle_limit = 4'd0;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(40);
    check(1'b0, "R1 zero limit never sets");
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(4);
    idle_limit = 4'd0;
    ticks(10);
    idle_limit = 4'd2;
    ticks(20);
    check(1'b0, "R1 zero limit abandons count");
    step(0, 1, 0, 0);
    ticks(8);
    check(1'b1, "R1 new character after re-enable arms");
  endtask

  task automatic t_arm();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(8);
    check(1'b1, "R8 setup expired");
    step(0, 1, 1, 0);
    check(1'b0, "R8 start clears flag");
    ticks(12);
    check(1'b0, "R8 character with start ignored");
    step(0, 1, 0, 0);
    ticks(8);
    check(1'b1, "R8 first character after start arms");
  endtask

  task automatic t_race();
    idle_limit = 4'd2;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(7);
    step(1, 0, 0, 1);
    check(1'b1, "R10 expiry beats clear");
  endtask

  task automatic t_max();
    idle_limit = 4'd15;
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(59);
    check(1'b0, "R3 full scale before last tick");
    ticks(1);
    check(1'b1, "R3 full scale expiry at 60 ticks");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_no_char();
    t_basic();
    t_reload();
    t_priority();
    t_sticky_clear();
    t_zero();
    t_arm();
    t_race();
    t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule